// File: doc/BRIEF.md
# Port-to-Flow Lookup Map

This block turns the logical port address carried by incoming traffic into a flow identifier for one ingress direction. It holds one 8-bit entry for every possible port address. Each entry has an identifier, an enable flag and a flag that reverses the bit order of the port's data bytes. A port whose entry is disabled is disconnected, so its traffic is never marked valid.

Software programs the table through an indirect command port. It places an address and a data word on the port, issues a read or a write, waits while the busy flag is high, and then reads back a result code and, for a read, the entry. The block rejects any write that would let two enabled ports share one identifier. Because there are only 64 identifiers, no more than 64 ports can be active at once. On the traffic side, each lookup takes one registered cycle and returns the identifier, a valid flag and the data byte, reversed when the entry asks for it.

Top module: `port_flow_map`

## Requirements
- R1: After reset every entry is disabled, `out_valid`, `out_flow`, `out_byte`, `ind_busy` and `ind_rdata` are 0, and `ind_code` is 0x00.
- R2: An entry is 8 bits. Bits 5:0 hold the flow identifier, bit 6 is the enable and bit 7 is the reversal flag. A read returns the entry exactly as the last accepted write stored it.
- R3: A lookup presented with `lk_valid` high at clock edge k appears on the outputs after edge k. At that point `out_valid` equals `lk_valid` AND the entry's enable, and `out_flow` is the entry's identifier. Whenever `out_valid` is low, `out_flow` and `out_byte` are 0.
- R4: A lookup on a port whose enable bit is 0 gives `out_valid` = 0, `out_flow` = 0 and `out_byte` = 0.
- R5: When the entry's reversal bit is 1, `out_byte` bit i equals `lk_byte` bit 7-i (for example 0xB4 becomes 0x2D). When the reversal bit is 0, the byte passes through unchanged.
- R6: A command accepted at edge k raises `ind_busy` for exactly one cycle, after edge k. After edge k+1, `ind_busy` is 0 and the result code and read data are valid. A command issued while `ind_busy` is high is ignored.
- R7: A write whose entry is enabled and whose identifier is already held by a different enabled port is rejected. The result code is 0x01 and the table is left unchanged.
- R8: The duplicate check considers only enabled entries at other ports. Rewriting a port with its own identifier is accepted, a disabled entry is always accepted, and disabling a port frees its identifier. An accepted write returns code 0x00.
- R9: The result code always describes the most recent command. A read always reports 0x00, even right after a rejected write.
- R10: With 64 ports enabled on 64 distinct identifiers, any write that enables a further port is rejected with code 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ind_cmd_valid | input | 1 | Command strobe |
| ind_cmd_write | input | 1 | 1 = write, 0 = read |
| ind_addr | input | 8 | Port address of the entry to access |
| ind_wdata | input | 8 | Entry value for a write |
| ind_busy | output | 1 | A command is being executed |
| ind_rdata | output | 8 | Entry returned by the last read |
| ind_code | output | 8 | Result code of the last command |
| lk_valid | input | 1 | Lookup request |
| lk_port | input | 8 | Port address to translate |
| lk_byte | input | 8 | Data byte of the port |
| out_valid | output | 1 | Translated traffic is forwarded |
| out_flow | output | 6 | Flow identifier |
| out_byte | output | 8 | Data byte, reversed if the entry asks for it |

## Verification
The bench builds the block with its default parameters: an 8-bit port address (256 entries), a 6-bit identifier (64 flows) and an 8-bit data byte. These sizes place both extremes within reach of a short run. The bench uses the highest port (0xFF) and the highest identifier (63), and it fills the table until every identifier is held, so the 65th enable meets a full flow space. Small tables would not reach the exhaustion case, and larger ones would only lengthen the fill.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] CODE_OK  = 8'h00;
    localparam logic [CODE_W-1:0] CODE_DUP = 8'h01;
endpackage

// File: rtl/pfm_flow_owner.sv
module pfm_flow_owner #(
    parameter int PORT_W = 8,
    parameter int FLOW_W = 6,
    localparam int FLOWS = 1 << FLOW_W,
    localparam int ENT_W = FLOW_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] chk_port,
    input  logic [ENT_W-1:0]  new_entry,
    input  logic [ENT_W-1:0]  old_entry,
    input  logic              commit_en,
    output logic              conflict
);
    typedef struct packed {
        logic [FLOWS-1:0]             held;
        logic [FLOWS-1:0][PORT_W-1:0] holder;
    } own_t;

    own_t q, d;

    logic [FLOW_W-1:0] new_id, old_id;
    logic              new_en, old_en;

    assign new_id = new_entry[FLOW_W-1:0];
    assign new_en = new_entry[FLOW_W];
    assign old_id = old_entry[FLOW_W-1:0];
    assign old_en = old_entry[FLOW_W];

    // Another enabled port already owns the requested identifier
    assign conflict = new_en && q.held[new_id] && (q.holder[new_id] != chk_port);

    always_comb begin
        d = q;
        if (commit_en) begin
            if (old_en) d.held[old_id] = 1'b0;
            if (new_en) begin
                d.held[new_id]   = 1'b1;
                d.holder[new_id] = chk_port;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: an accepted enabling write leaves the identifier owned by that port
    a_r8_claim_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && new_en) |=> (q.held[$past(new_id)] && q.holder[$past(new_id)] == $past(chk_port)));
endmodule

// File: rtl/pfm_map_store.sv
module pfm_map_store #(
    parameter int PORT_W = 8,
    parameter int FLOW_W = 6,
    parameter int BYTE_W = 8,
    localparam int PORTS = 1 << PORT_W,
    localparam int ENT_W = FLOW_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] rd_addr,
    output logic [ENT_W-1:0]  rd_entry,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_addr,
    input  logic [ENT_W-1:0]  wr_entry,
    input  logic              lk_valid,
    input  logic [PORT_W-1:0] lk_port,
    input  logic [BYTE_W-1:0] lk_byte,
    output logic              out_valid,
    output logic [FLOW_W-1:0] out_flow,
    output logic [BYTE_W-1:0] out_byte
);
    typedef struct packed {
        logic [PORTS-1:0][ENT_W-1:0] tbl;
        logic                        vld;
        logic [FLOW_W-1:0]           flow;
        logic [BYTE_W-1:0]           byt;
    } st_t;

    st_t q, d;

    logic [ENT_W-1:0]  lk_ent;
    logic [BYTE_W-1:0] lk_byte_rev;
    logic              lk_hit;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
        assign lk_byte_rev[i] = lk_byte[BYTE_W-1-i];
    end

    assign lk_ent   = q.tbl[lk_port];
    assign lk_hit   = lk_valid && lk_ent[FLOW_W];
    assign rd_entry = q.tbl[rd_addr];

    always_comb begin
        d = q;
        if (wr_en) d.tbl[wr_addr] = wr_entry;
        d.vld  = lk_hit;
        d.flow = lk_hit ? lk_ent[FLOW_W-1:0] : '0;
        d.byt  = !lk_hit ? '0 : (lk_ent[FLOW_W+1] ? lk_byte_rev : lk_byte);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.vld;
    assign out_flow  = q.flow;
    assign out_byte  = q.byt;

    // R3: no output without a request one cycle earlier
    a_r3_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(lk_valid));
    // R4: idle outputs are held at zero
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_flow == '0 && out_byte == '0));
    // R2: a committed entry is stored as written
    a_r2_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q.tbl[$past(wr_addr)] == $past(wr_entry)));
endmodule

// File: rtl/pfm_cmd_ctrl.sv
module pfm_cmd_ctrl
    import pfm_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int FLOW_W = 6,
    localparam int ENT_W = FLOW_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [PORT_W-1:0] cmd_addr,
    input  logic [ENT_W-1:0]  cmd_wdata,
    input  logic              conflict,
    input  logic [ENT_W-1:0]  old_entry,
    output logic [PORT_W-1:0] op_addr,
    output logic [ENT_W-1:0]  op_wdata,
    output logic              commit_en,
    output logic              busy,
    output logic [CODE_W-1:0] code,
    output logic [ENT_W-1:0]  rdata
);
    typedef struct packed {
        logic              busy;
        logic              wr;
        logic [PORT_W-1:0] addr;
        logic [ENT_W-1:0]  wdata;
        logic [CODE_W-1:0] code;
        logic [ENT_W-1:0]  rdata;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (q.busy) begin
            d.busy = 1'b0;
            if (q.wr) begin
                d.code = conflict ? CODE_DUP : CODE_OK;
            end else begin
                d.code  = CODE_OK;
                d.rdata = old_entry;
            end
        end else if (cmd_valid) begin
            d.busy  = 1'b1;
            d.wr    = cmd_write;
            d.addr  = cmd_addr;
            d.wdata = cmd_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign commit_en = q.busy && q.wr && !conflict;
    assign op_addr   = q.addr;
    assign op_wdata  = q.wdata;
    assign busy      = q.busy;
    assign code      = q.code;
    assign rdata     = q.rdata;

    // R6: busy lasts a single cycle
    a_r6_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R7: a clashing write reports the duplicate code
    a_r7_dup_code: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.wr && conflict) |=> (code == CODE_DUP));
    // R9: a read always reports normal completion
    a_r9_read_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !q.wr) |=> (code == CODE_OK));
endmodule

// File: rtl/port_flow_map.sv
module port_flow_map
    import pfm_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int FLOW_W = 6,
    parameter int BYTE_W = 8,
    localparam int ENT_W = FLOW_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ind_cmd_valid,
    input  logic              ind_cmd_write,
    input  logic [PORT_W-1:0] ind_addr,
    input  logic [ENT_W-1:0]  ind_wdata,
    output logic              ind_busy,
    output logic [ENT_W-1:0]  ind_rdata,
    output logic [CODE_W-1:0] ind_code,
    input  logic              lk_valid,
    input  logic [PORT_W-1:0] lk_port,
    input  logic [BYTE_W-1:0] lk_byte,
    output logic              out_valid,
    output logic [FLOW_W-1:0] out_flow,
    output logic [BYTE_W-1:0] out_byte
);
    logic [PORT_W-1:0] op_addr;
    logic [ENT_W-1:0]  op_wdata;
    logic [ENT_W-1:0]  old_entry;
    logic              commit_en;
    logic              conflict;

    pfm_cmd_ctrl #(.PORT_W(PORT_W), .FLOW_W(FLOW_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (ind_cmd_valid),
        .cmd_write (ind_cmd_write),
        .cmd_addr  (ind_addr),
        .cmd_wdata (ind_wdata),
        .conflict  (conflict),
        .old_entry (old_entry),
        .op_addr   (op_addr),
        .op_wdata  (op_wdata),
        .commit_en (commit_en),
        .busy      (ind_busy),
        .code      (ind_code),
        .rdata     (ind_rdata)
    );

    pfm_flow_owner #(.PORT_W(PORT_W), .FLOW_W(FLOW_W)) u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_port  (op_addr),
        .new_entry (op_wdata),
        .old_entry (old_entry),
        .commit_en (commit_en),
        .conflict  (conflict)
    );

    pfm_map_store #(.PORT_W(PORT_W), .FLOW_W(FLOW_W), .BYTE_W(BYTE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (op_addr),
        .rd_entry  (old_entry),
        .wr_en     (commit_en),
        .wr_addr   (op_addr),
        .wr_entry  (op_wdata),
        .lk_valid  (lk_valid),
        .lk_port   (lk_port),
        .lk_byte   (lk_byte),
        .out_valid (out_valid),
        .out_flow  (out_flow),
        .out_byte  (out_byte)
    );
endmodule

// File: tb/tb_port_flow_map.sv
module tb_port_flow_map;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ind_cmd_valid = 1'b0;
    logic       ind_cmd_write = 1'b0;
    logic [7:0] ind_addr = '0;
    logic [7:0] ind_wdata = '0;
    logic       ind_busy;
    logic [7:0] ind_rdata;
    logic [7:0] ind_code;
    logic       lk_valid = 1'b0;
    logic [7:0] lk_port = '0;
    logic [7:0] lk_byte = '0;
    logic       out_valid;
    logic [5:0] out_flow;
    logic [7:0] out_byte;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    port_flow_map dut (.*);

    // kind: 0 write (expect = code), 1 read (expect = entry), 2 lookup (expect = {valid,0,flow,byte})
    localparam logic [33:0] VEC [16] = '{
        {2'd0, 8'h10, 8'h45, 16'h0000},  // R2 enable id 5
        {2'd2, 8'h10, 8'h3C, 16'h853C},  // R3 straight lookup
        {2'd0, 8'h20, 8'h45, 16'h0001},  // R7 duplicate
        {2'd1, 8'h20, 8'h00, 16'h0000},  // R7 unchanged, R9 read code ok
        {2'd0, 8'h10, 8'hC5, 16'h0000},  // R8 same port, same id
        {2'd2, 8'h10, 8'hB4, 16'h852D},  // R5 reversed
        {2'd0, 8'h20, 8'h05, 16'h0000},  // R8 disabled entry accepted
        {2'd2, 8'h20, 8'hFF, 16'h0000},  // R4 disabled port
        {2'd0, 8'h10, 8'h09, 16'h0000},  // R8 disable frees id 5
        {2'd0, 8'h20, 8'h45, 16'h0000},  // R8 id 5 now free
        {2'd2, 8'h20, 8'h01, 16'h8501},  // R3 lookup
        {2'd1, 8'h10, 8'h00, 16'h0009},  // R2 readback
        {2'd0, 8'hFF, 8'hFF, 16'h0000},  // R2 top port, id 63
        {2'd2, 8'hFF, 8'h01, 16'hBF80},  // R5 top port reversed
        {2'd0, 8'h00, 8'h7F, 16'h0001},  // R7 id 63 taken
        {2'd1, 8'h00, 8'h00, 16'h0000}   // R7 entry untouched
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic wr, input logic [7:0] a, input logic [7:0] dat,
                          input string req, input logic [15:0] exp);
        @(negedge clk);
        ind_cmd_valid = 1'b1; ind_cmd_write = wr; ind_addr = a; ind_wdata = dat;
        @(negedge clk);
        ind_cmd_valid = 1'b0;
        check("R6 busy", {15'd0, ind_busy}, 16'd1);
        @(negedge clk);
        check("R6 done", {15'd0, ind_busy}, 16'd0);
        if (wr) check(req, {8'd0, ind_code}, exp);
        else begin
            check(req, {8'd0, ind_rdata}, exp);
            check("R9 read code", {8'd0, ind_code}, 16'h0000);
        end
    endtask

    task automatic do_look(input logic [7:0] p, input logic [7:0] b, input string req,
                           input logic [15:0] exp);
        @(negedge clk);
        lk_valid = 1'b1; lk_port = p; lk_byte = b;
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, {out_valid, 1'b0, out_flow, out_byte}, exp);
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 outputs", {out_valid, 1'b0, out_flow, out_byte}, 16'h0000);
        check("R1 cmd", {7'd0, ind_busy, ind_code}, 16'h0000);
        check("R1 rdata", {8'd0, ind_rdata}, 16'h0000);
        rst_n = 1'b1;
        do_look(8'h10, 8'hAA, "R1 entry disabled", 16'h0000);

        foreach (VEC[i]) begin
            case (VEC[i][33:32])
                2'd0: do_cmd(1'b1, VEC[i][31:24], VEC[i][23:16], "R7/R8 vec write", VEC[i][15:0]);
                2'd1: do_cmd(1'b0, VEC[i][31:24], 8'h00, "R2 vec read", VEC[i][15:0]);
                default: do_look(VEC[i][31:24], VEC[i][23:16], "R3/R5 vec lookup", VEC[i][15:0]);
            endcase
        end

        // R3: no request, no output
        @(negedge clk);
        lk_valid = 1'b0; lk_port = 8'h20; lk_byte = 8'h55;
        @(negedge clk);
        check("R3 no request", {out_valid, 1'b0, out_flow, out_byte}, 16'h0000);

        // R6: a command issued while busy is ignored
        @(negedge clk);
        ind_cmd_valid = 1'b1; ind_cmd_write = 1'b1; ind_addr = 8'h30; ind_wdata = 8'h0A;
        @(negedge clk);
        ind_wdata = 8'h8B;
        check("R6 busy", {15'd0, ind_busy}, 16'd1);
        @(negedge clk);
        ind_cmd_valid = 1'b0;
        check("R6 done", {15'd0, ind_busy}, 16'd0);
        @(negedge clk);
        do_cmd(1'b0, 8'h30, 8'h00, "R6 ignored command", 16'h000A);

        // R10: fill every identifier (ids 5 and 63 already held)
        for (int i = 0; i < 64; i++) begin
            do_cmd(1'b1, 8'h40 + 8'(i), {2'b01, 6'(i)},
                   "R10 fill", (i == 5 || i == 63) ? 16'h0001 : 16'h0000);
        end
        do_cmd(1'b1, 8'h80, 8'h47, "R10 flow space full", 16'h0001);
        do_cmd(1'b0, 8'h80, 8'h00, "R10 entry untouched", 16'h0000);
        do_look(8'h41, 8'h0F, "R10 lookup", 16'h810F);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule